// File: doc/BRIEF.md
# 64-bit Interval Timer

This block is a 64-bit up-counting interval timer that sits on a simple 32-bit read/write strobe bus. Software programs a period in two halves, picks continuous or single-run behaviour, picks the count tick source and a divider from 1 to 16, and then issues a start command. Each time the count reaches the period, a pending flag is raised. If the flag's enable is set, the interrupt line follows it. Reading the status register returns the flag and clears it.

The count tick is either every cycle of the bus clock or an alternate tick enable, `alt_tick`. The alternate tick stands in for a slower second clock, and its source must pulse at no more than one third of the bus clock rate. The live count can be read as two halves. Reading the low half freezes a copy of the high half, so a later read of the high half always matches, however long after it comes. One control register carries both the start command and a software reset. The half width is a parameter (`HALF_W`, default 32), so the count is `2*HALF_W` bits wide.

Top module: `interval_timer64`

## Requirements
- R1: After reset the timer is stopped with count zero, period all ones, mode zero, interrupt enable zero, pending flag zero and `irq` low; while stopped the count does not change.
- R2: A write to offset 0x0C only stages the upper period half. A write to 0x08 commits the full period as {staged upper, written lower}. Reads of 0x08 and 0x0C return the committed lower and upper halves.
- R3: Writing control (0x00) with bit 0 set starts counting and restarts the divider. Mode (0x04) holds the divide value p in bits 11:8, and the count advances once every p+1 selected ticks. Mode reads back bit 0, bit 3 and bits 11:8, with zeros elsewhere.
- R4: With mode bit 0 set (continuous), an advance taken while the count equals the period sets the pending flag and returns the count to zero, and counting goes on.
- R5: With mode bit 0 clear (single run), the same event sets the flag, returns the count to zero and stops the timer until the next start command.
- R6: With mode bit 3 set, ticks come only from cycles where `alt_tick` is high. With it clear, every clock cycle is a tick and `alt_tick` is ignored.
- R7: Writing control with bit 8 set stops the timer and zeroes the count and the divider. It takes priority over bit 0 in the same write and leaves the pending flag unchanged.
- R8: Reading the count low half (0x20) captures the count's upper half at that same cycle. A read of 0x24 returns that captured value.
- R9: Status (0x1C) bit 0 returns the pending flag. The read clears the flag, unless a new period event happens in the same cycle, in which case the flag stays set.
- R10: `irq` is high exactly when the pending flag and interrupt enable (0x10 bit 0) are both set. It rises the cycle after a period event when the enable is set.
- R11: Reads of the control offset and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_tick | input | 1 | Alternate count tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, combinational from `addr` |
| irq | output | 1 | Period interrupt |

## Verification
The hardest case to reach is a carry from the low half of the count into the high half that falls between a low-half read and the matching high-half read. With 32-bit halves, that would take billions of cycles. The bench therefore builds the timer with 8-bit halves. It runs continuously with the largest period up to count 0xFF, reads the low half, and waits past the carry before reading the high half. It expects the frozen zero, and then the fresh value after a second pair of reads. Single-run stops and wraps are placed by counting clock edges from the start write, so each expected count follows from the elapsed cycles and the divide value.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_MODE   = 8'h04;
    localparam logic [7:0] OFS_PER_LO = 8'h08;
    localparam logic [7:0] OFS_PER_HI = 8'h0C;
    localparam logic [7:0] OFS_IEN    = 8'h10;
    localparam logic [7:0] OFS_STAT   = 8'h1C;
    localparam logic [7:0] OFS_CNT_LO = 8'h20;
    localparam logic [7:0] OFS_CNT_HI = 8'h24;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_RST_BIT  = 8;
    localparam int MODE_CONT_BIT = 0;
    localparam int MODE_ALT_BIT  = 3;
    localparam int MODE_DIV_LSB  = 8;
    localparam int DIV_W         = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             alt;
        logic             cont;
    } mode_t;
endpackage

// File: rtl/ivt_divider.sv
module ivt_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             use_alt,
    input  logic             alt_tick,
    input  logic [DIV_W-1:0] div,
    output logic             adv
);
    logic [DIV_W-1:0] phase_d, phase_q;
    logic             tick;

    always_comb begin
        tick    = use_alt ? alt_tick : 1'b1;
        adv     = run && tick && (phase_q == div);
        phase_d = phase_q;
        if (restart) begin
            phase_d = '0;
        end else if (run && tick) begin
            phase_d = adv ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             halt,
    input  logic             adv,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             wrap
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = adv && (s_q.cnt == period);
        if (halt) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else begin
            if (adv) begin
                if (wrap) begin
                    s_d.cnt = '0;
                    if (!cont) s_d.run = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (go) s_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign run = s_q.run;
endmodule

// File: rtl/interval_timer64.sv
module interval_timer64
    import ivt_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    typedef struct packed {
        mode_t             mode;
        logic [CNT_W-1:0]  period;
        logic [HALF_W-1:0] stage;
        logic [HALF_W-1:0] snap;
        logic              ie;
        logic              flag;
    } regs_t;

    regs_t r_d, r_q;

    logic             wr_ctrl, wr_mode, wr_plo, wr_phi, wr_ien;
    logic             rd_clo, rd_stat;
    logic             go, swrst, adv, wrap, run;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        wr_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
        wr_mode = wr_en && (addr == ADDR_W'(OFS_MODE));
        wr_plo  = wr_en && (addr == ADDR_W'(OFS_PER_LO));
        wr_phi  = wr_en && (addr == ADDR_W'(OFS_PER_HI));
        wr_ien  = wr_en && (addr == ADDR_W'(OFS_IEN));
        rd_clo  = rd_en && (addr == ADDR_W'(OFS_CNT_LO));
        rd_stat = rd_en && (addr == ADDR_W'(OFS_STAT));
        swrst   = wr_ctrl && wdata[CTRL_RST_BIT];
        go      = wr_ctrl && wdata[CTRL_GO_BIT] && !wdata[CTRL_RST_BIT];
    end

    ivt_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (go || swrst),
        .use_alt  (r_q.mode.alt),
        .alt_tick (alt_tick),
        .div      (r_q.mode.div),
        .adv      (adv)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .halt   (swrst),
        .adv    (adv),
        .cont   (r_q.mode.cont),
        .period (r_q.period),
        .cnt    (cnt),
        .run    (run),
        .wrap   (wrap)
    );

    always_comb begin
        r_d   = r_q;
        rdata = '0;
        if (wr_mode) begin
            r_d.mode.cont = wdata[MODE_CONT_BIT];
            r_d.mode.alt  = wdata[MODE_ALT_BIT];
            r_d.mode.div  = wdata[MODE_DIV_LSB +: DIV_W];
        end
        if (wr_phi) r_d.stage  = wdata[HALF_W-1:0];
        if (wr_plo) r_d.period = {r_q.stage, wdata[HALF_W-1:0]};
        if (wr_ien) r_d.ie     = wdata[0];
        if (rd_clo) r_d.snap   = cnt[CNT_W-1:HALF_W];
        if (rd_stat) r_d.flag  = 1'b0;
        if (wrap)    r_d.flag  = 1'b1;

        case (addr)
            ADDR_W'(OFS_MODE): begin
                rdata[MODE_CONT_BIT]                = r_q.mode.cont;
                rdata[MODE_ALT_BIT]                 = r_q.mode.alt;
                rdata[MODE_DIV_LSB +: DIV_W]        = r_q.mode.div;
            end
            ADDR_W'(OFS_PER_LO): rdata = BUS_W'(r_q.period[HALF_W-1:0]);
            ADDR_W'(OFS_PER_HI): rdata = BUS_W'(r_q.period[CNT_W-1:HALF_W]);
            ADDR_W'(OFS_IEN):    rdata = BUS_W'(r_q.ie);
            ADDR_W'(OFS_STAT):   rdata = BUS_W'(r_q.flag);
            ADDR_W'(OFS_CNT_LO): rdata = BUS_W'(cnt[HALF_W-1:0]);
            ADDR_W'(OFS_CNT_HI): rdata = BUS_W'(r_q.snap);
            default:             rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.period <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq = r_q.flag && r_q.ie;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic                rst_bit,
    input logic                irq,
    input logic                run,
    input logic [2*HALF_W-1:0] cnt,
    input logic [HALF_W-1:0]   snap,
    input logic                flag,
    input logic                ie,
    input logic                wrap,
    input logic                cont
);
    localparam int CNT_W = 2 * HALF_W;

    assert_swrst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == ADDR_W'(OFS_CTRL) && rst_bit |=> !run && cnt == '0);

    assert_idle_count_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !(wr_en && addr == ADDR_W'(OFS_CTRL)) |=> $stable(cnt));

    assert_upper_captured_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(OFS_CNT_LO) |=> snap == $past(cnt[CNT_W-1:HALF_W]));

    assert_single_run_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run && !cont && wrap && !(wr_en && addr == ADDR_W'(OFS_CTRL)) |=> !run && cnt == '0);

    assert_status_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(OFS_STAT) && !wrap |=> !flag);

    assert_event_raises_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && ie && !(wr_en && addr == ADDR_W'(OFS_IEN)) |=> irq);
endmodule

bind interval_timer64 ivt_checker #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .rst_bit (wdata[ivt_pkg::CTRL_RST_BIT]),
    .irq     (irq),
    .run     (run),
    .cnt     (cnt),
    .snap    (r_q.snap),
    .flag    (r_q.flag),
    .ie      (r_q.ie),
    .wrap    (wrap),
    .cont    (r_q.mode.cont)
);

// File: tb/interval_timer64_test.sv
`timescale 1ns/1ps
module interval_timer64_test;
    localparam int HW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int cyc = 0;
    int t0 = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    interval_timer64 #(.HALF_W(HW), .BUS_W(32), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: samples one nanosecond before the rising edge
    always begin
        @(negedge clk);
        #3;
        if (rd_en) begin
            n_cmp++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        sb.push_back('{e, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start();
        wr(8'h00, 32'h1);
        t0 = cyc;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #3;
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: actual irq %b expected %b", tag, irq, e);
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h20, 32'h0,  "R1 count");
        rd(8'h08, 32'hFF, "R1 period lo");
        rd(8'h0C, 32'hFF, "R1 period hi");
        rd(8'h04, 32'h0,  "R1 mode");
        rd(8'h10, 32'h0,  "R1 enable");
        rd(8'h1C, 32'h0,  "R1 status");
        chk_irq(1'b0, "R1 irq");
        idle(5);
        rd(8'h20, 32'h0,  "R1 count frozen while stopped");

        // R11 control and unmapped offsets
        rd(8'h00, 32'h0, "R11 control reads zero");
        rd(8'h14, 32'h0, "R11 unmapped 0x14");
        rd(8'h2C, 32'h0, "R11 unmapped 0x2C");

        // R2 staged period commit
        wr(8'h0C, 32'h12);
        rd(8'h0C, 32'hFF, "R2 upper not yet committed");
        wr(8'h08, 32'h05);
        rd(8'h0C, 32'h12, "R2 upper committed");
        rd(8'h08, 32'h05, "R2 lower committed");

        // R3 mode field positions
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0000_0F09, "R3 mode readback");

        // R4 continuous wrap with period 9, divide 1
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h9);
        wr(8'h10, 32'h1);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h100);
        start();
        rd(8'h20, 32'h0, "R3 count right after start");
        idle(24);
        rd(8'h20, 32'h5, "R4 count after 25 ticks mod 10");
        chk_irq(1'b1, "R10 irq after period event");
        // R7 software reset keeps flag
        wr(8'h00, 32'h100);
        rd(8'h20, 32'h0, "R7 count cleared");
        idle(3);
        rd(8'h20, 32'h0, "R7 stays stopped");
        rd(8'h1C, 32'h1, "R9 flag kept through reset, read");
        rd(8'h1C, 32'h0, "R9 flag cleared by read");
        chk_irq(1'b0, "R10 irq low after clear");

        // R3 divide by 4 (p=3), continuous, large period
        wr(8'h0C, 32'hFF);
        wr(8'h08, 32'hFF);
        wr(8'h04, 32'h301);
        start();
        idle(9);
        rd(8'h20, 32'h2, "R3 divide by 4 after 9 cycles");
        idle(6);
        rd(8'h20, 32'h4, "R3 divide by 4 after 16 cycles");

        // R5 single run, p=1, period 4, interrupt disabled
        wr(8'h00, 32'h100);
        wr(8'h10, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h4);
        wr(8'h04, 32'h100);
        start();
        idle(3);
        rd(8'h20, 32'h1, "R5 count before stop");
        idle(20);
        rd(8'h20, 32'h0, "R5 stopped at zero");
        chk_irq(1'b0, "R10 irq masked when enable clear");
        rd(8'h1C, 32'h1, "R5 flag set by single run");
        start();
        idle(4);
        rd(8'h20, 32'h2, "R5 restart counts again");

        // R7 reset wins over start in same write
        wr(8'h00, 32'h101);
        rd(8'h20, 32'h0, "R7 reset with start bit");
        idle(3);
        rd(8'h20, 32'h0, "R7 start ignored");

        // R6 alternate tick source
        wr(8'h0C, 32'hFF);
        wr(8'h08, 32'hFF);
        wr(8'h04, 32'h9);
        start();
        idle(10);
        rd(8'h20, 32'h0, "R6 no count without alternate tick");
        alt_tick = 1'b1;
        idle(5);
        alt_tick = 1'b0;
        rd(8'h20, 32'h5, "R6 five alternate ticks");
        idle(3);
        rd(8'h20, 32'h5, "R6 holds without ticks");

        // R8 coherent read across the half carry
        wr(8'h00, 32'h100);
        wr(8'h04, 32'h1);
        start();
        idle(255);
        rd(8'h20, 32'hFF, "R8 low half before carry");
        idle(4);
        rd(8'h24, 32'h00, "R8 high half frozen at low read");
        rd(8'h20, 32'h05, "R8 low half after carry");
        rd(8'h24, 32'h01, "R8 high half after fresh low read");

        idle(2);
        finish_run();
    end
endmodule